// File: doc/BRIEF.md
# Tag-Port Request Arbiter with Controller Preemption

This block decides which request reaches the tag array read port in each cycle. Each hardware thread can present a fresh (normal) request and a replayed (recycled) request that missed earlier. A cache controller can also present an update command. The controller update wins outright. Otherwise the block grants one eligible thread in rotating order. Inside the granted thread it takes the recycled request first, so that replays keep their place ahead of younger work.

The block keeps a mask of sleeping threads. A miss reported by the last pipeline stage sets a thread's bit. A wakeup, given as a one-hot thread vector qualified by a strobe, clears it. Eligibility uses the already-updated mask, so a thread that misses in this cycle is excluded at once. The block drives the tag read index, the per-thread dequeue and recycle-acknowledge masks, and a registered stage output. That output carries the selected address, the winning thread, the source of the request and the decoded command flags.

Top module: `ldst_req_arbiter`

## Requirements
- R1: Reset clears the stage valid and the sleeping mask, and returns the rotation to thread 0. The first grant after reset, with all threads requesting, goes to thread 0.
- R2: A thread is granted only if it has a normal or recycled request, is not in the updated sleeping mask, and no controller update is valid.
- R3: At most one thread is granted per cycle. The search starts at the thread after the most recently granted one and wraps around.
- R4: If the granted thread has both a recycled and a normal request, only its recycle-acknowledge bit is raised, and the recycled address is selected.
- R5: While the controller valid is high, no dequeue or recycle bit is raised. The tag read index is the controller address index (the low IDX_W bits), and the stage captures the controller address with its from-controller flag set.
- R6: The rotation pointer moves only on a cycle that grants a thread. Controller cycles leave it unchanged.
- R7: The updated sleeping mask is (current mask OR miss bits) AND NOT (wakeup one-hot AND strobe). A thread whose bit is set receives no grant until it is woken.
- R8: When a miss and a strobed wakeup name the same thread in one cycle, the wakeup wins and that thread stays eligible. A wakeup without its strobe has no effect.
- R9: The command codes are 0 complete-instruction, 1 update-info, 2 update-info-with-data and 3 replacement. One cycle after a controller update, the stage update-with-data flag is 1 for codes 2 and 3, and the stage evict flag is 1 only for code 3.
- R10: An update-info command (code 1) forwards nothing: the stage valid is 0 in the next cycle.
- R11: One cycle after a thread grant, the stage valid is 1, the stage address is the granted request's address and the stage thread is the winner's index. After a cycle with neither grant nor forwarded command, the stage valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrNormValid | input | NUM_THREADS | Normal request valid per thread |
| thrRecValid | input | NUM_THREADS | Recycled request valid per thread |
| thrNormAddr | input | NUM_THREADS*ADDR_W | Normal request addresses, thread t at bits t*ADDR_W |
| thrRecAddr | input | NUM_THREADS*ADDR_W | Recycled request addresses, same packing |
| ctrlValid | input | 1 | Controller update valid |
| ctrlCmd | input | 2 | Controller command code |
| ctrlAddr | input | ADDR_W | Controller address {tag, index} |
| missSleep | input | NUM_THREADS | Miss-induced sleep bits from the last stage |
| wakeStrobe | input | 1 | Qualifies the wakeup vector |
| wakeThreadOh | input | NUM_THREADS | One-hot thread to wake |
| tagReadIdx | output | IDX_W | Tag array read index (0 when nothing is selected) |
| normDequeue | output | NUM_THREADS | Normal request consumed |
| recycleAck | output | NUM_THREADS | Recycled request consumed |
| stgValid | output | 1 | Stage register valid |
| stgAddr | output | ADDR_W | Stage register address |
| stgThread | output | THR_W | Stage register winning thread |
| stgFromCtrl | output | 1 | Stage entry came from the controller |
| stgUpdData | output | 1 | Stage entry updates tags and data |
| stgEvict | output | 1 | Stage entry is a replacement |

## Verification
A miss report and a wakeup can land in the same cycle, and either can coincide with a request from the affected thread. The bench drives a miss and a strobed wakeup for one thread while that thread requests, and expects an immediate grant. It then drives a miss for one thread with a wakeup for another, and expects the missing thread to be skipped at once and again in the next cycle. Controller preemption is also placed between thread grants. The next thread grant must then come from the pointer position held across the controller cycles.

// File: rtl/ldst_arb_pkg.sv
package ldst_arb_pkg;
  typedef enum logic [1:0] {
    CMD_INSTR     = 2'd0,
    CMD_INFO      = 2'd1,
    CMD_INFO_DATA = 2'd2,
    CMD_REPLACE   = 2'd3
  } ctrlCmd_e;

  typedef struct packed {
    logic grant;     // a thread request was granted
    logic useRec;    // granted thread is served from its recycled slot
    logic ctrlSel;   // controller owns the tag port this cycle
    logic fwdValid;  // something is forwarded to the stage register
    logic updData;   // update with data (info+data or replacement)
    logic evict;     // replacement
  } arbStrobe_t;
endpackage

// File: rtl/ldst_arb_ctrl.sv
module ldst_arb_ctrl
  import ldst_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] normValid,
  input  logic [NUM_THREADS-1:0] recValid,
  input  logic                   ctrlValid,
  input  logic [1:0]             ctrlCmd,
  input  logic [NUM_THREADS-1:0] missSleep,
  input  logic                   wakeStrobe,
  input  logic [NUM_THREADS-1:0] wakeThreadOh,
  output arbStrobe_t             stb,
  output logic [THR_W-1:0]       winId,
  output logic [NUM_THREADS-1:0] normDeq,
  output logic [NUM_THREADS-1:0] recAck
);
  logic [NUM_THREADS-1:0] sleepMask, sleepNext, wakeMask, eligible, grantMask;
  logic [THR_W-1:0]       ptr;
  logic                   found;
  ctrlCmd_e               cmdE;

  always_comb begin
    int c;
    wakeMask  = wakeThreadOh & {NUM_THREADS{wakeStrobe}};
    sleepNext = (sleepMask | missSleep) & ~wakeMask;
    eligible  = (normValid | recValid) & ~sleepNext & {NUM_THREADS{~ctrlValid}};
    found = 1'b0;
    winId = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      c = int'(ptr) + k;
      if (c >= NUM_THREADS) c = c - NUM_THREADS;
      if (!found && eligible[c]) begin
        found = 1'b1;
        winId = THR_W'(c);
      end
    end
    grantMask = found ? (NUM_THREADS'(1) << winId) : '0;
  end

  always_comb begin
    cmdE         = ctrlCmd_e'(ctrlCmd);
    stb.grant    = found;
    stb.useRec   = found && recValid[winId];
    stb.ctrlSel  = ctrlValid;
    stb.updData  = ctrlValid && (cmdE == CMD_INFO_DATA || cmdE == CMD_REPLACE);
    stb.evict    = ctrlValid && (cmdE == CMD_REPLACE);
    stb.fwdValid = ctrlValid ? (cmdE != CMD_INFO) : found;
    normDeq      = stb.useRec ? '0 : grantMask;
    recAck       = stb.useRec ? grantMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepMask <= '0;
      ptr       <= '0;
    end else begin
      sleepMask <= sleepNext;
      if (found)
        ptr <= (int'(winId) == NUM_THREADS - 1) ? '0 : winId + THR_W'(1);
    end
  end

  // R2
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((normDeq | recAck) & ~(normValid | recValid)) == '0);
  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(normDeq | recAck));
  // R4
  recycled_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normDeq & recValid) == '0);
  // R5
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid |-> (normDeq | recAck) == '0);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid |=> $stable(ptr));
  // R7
  sleeper_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((normDeq | recAck) & sleepMask & ~wakeMask) == '0);
endmodule

// File: rtl/ldst_arb_dp.sv
module ldst_arb_dp
  import ldst_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int IDX_W       = 6,
  parameter int TAG_W       = 8,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int THR_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  arbStrobe_t                    stb,
  input  logic [THR_W-1:0]              winId,
  input  logic [NUM_THREADS*ADDR_W-1:0] normAddr,
  input  logic [NUM_THREADS*ADDR_W-1:0] recAddr,
  input  logic [ADDR_W-1:0]             ctrlAddr,
  output logic [IDX_W-1:0]              tagReadIdx,
  output logic                          stgValid,
  output logic [ADDR_W-1:0]             stgAddr,
  output logic [THR_W-1:0]              stgThread,
  output logic                          stgFromCtrl,
  output logic                          stgUpdData,
  output logic                          stgEvict
);
  logic [ADDR_W-1:0] normArr [NUM_THREADS];
  logic [ADDR_W-1:0] recArr  [NUM_THREADS];
  logic [ADDR_W-1:0] selAddr;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_unpack
    assign normArr[g] = normAddr[g*ADDR_W +: ADDR_W];
    assign recArr[g]  = recAddr[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    if (stb.ctrlSel)      selAddr = ctrlAddr;
    else if (!stb.grant)  selAddr = '0;
    else if (stb.useRec)  selAddr = recArr[winId];
    else                  selAddr = normArr[winId];
    tagReadIdx = selAddr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgValid    <= 1'b0;
      stgAddr     <= '0;
      stgThread   <= '0;
      stgFromCtrl <= 1'b0;
      stgUpdData  <= 1'b0;
      stgEvict    <= 1'b0;
    end else begin
      stgValid    <= stb.fwdValid;
      stgAddr     <= selAddr;
      stgThread   <= winId;
      stgFromCtrl <= stb.ctrlSel;
      stgUpdData  <= stb.updData;
      stgEvict    <= stb.evict;
    end
  end

  // R11
  stage_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.grant |=> stgValid && !stgFromCtrl);
  // R9
  evict_implies_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    stgEvict |-> stgUpdData && stgFromCtrl);
endmodule

// File: rtl/ldst_req_arbiter.sv
module ldst_req_arbiter
  import ldst_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int IDX_W       = 6,
  parameter int TAG_W       = 8,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int THR_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        thrNormValid,
  input  logic [NUM_THREADS-1:0]        thrRecValid,
  input  logic [NUM_THREADS*ADDR_W-1:0] thrNormAddr,
  input  logic [NUM_THREADS*ADDR_W-1:0] thrRecAddr,
  input  logic                          ctrlValid,
  input  logic [1:0]                    ctrlCmd,
  input  logic [ADDR_W-1:0]             ctrlAddr,
  input  logic [NUM_THREADS-1:0]        missSleep,
  input  logic                          wakeStrobe,
  input  logic [NUM_THREADS-1:0]        wakeThreadOh,
  output logic [IDX_W-1:0]              tagReadIdx,
  output logic [NUM_THREADS-1:0]        normDequeue,
  output logic [NUM_THREADS-1:0]        recycleAck,
  output logic                          stgValid,
  output logic [ADDR_W-1:0]             stgAddr,
  output logic [THR_W-1:0]              stgThread,
  output logic                          stgFromCtrl,
  output logic                          stgUpdData,
  output logic                          stgEvict
);
  arbStrobe_t       stb;
  logic [THR_W-1:0] winId;

  ldst_arb_ctrl #(.NUM_THREADS(NUM_THREADS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .normValid(thrNormValid), .recValid(thrRecValid),
    .ctrlValid(ctrlValid), .ctrlCmd(ctrlCmd),
    .missSleep(missSleep), .wakeStrobe(wakeStrobe), .wakeThreadOh(wakeThreadOh),
    .stb(stb), .winId(winId), .normDeq(normDequeue), .recAck(recycleAck)
  );

  ldst_arb_dp #(.NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .winId(winId),
    .normAddr(thrNormAddr), .recAddr(thrRecAddr), .ctrlAddr(ctrlAddr),
    .tagReadIdx(tagReadIdx), .stgValid(stgValid), .stgAddr(stgAddr),
    .stgThread(stgThread), .stgFromCtrl(stgFromCtrl),
    .stgUpdData(stgUpdData), .stgEvict(stgEvict)
  );

  // R10
  info_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid && ctrlCmd == 2'd1 |=> !stgValid);
  // R9
  replace_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid && ctrlCmd == 2'd3 |=> stgEvict && stgUpdData);
endmodule

// File: tb/ldst_req_arbiter_test.sv
module ldst_req_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, IDX_W = 6, TAG_W = 8, ADDR_W = 14;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {8'hC5, 6'h3A};
  localparam int NROWS = 18;
  // {normV, recV, ctrlV, cmd, miss, wakeStb, wakeOh, expNormDeq, expRecAck}
  localparam logic [27:0] VEC [NROWS] = '{
    {4'b1111, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R1 first grant t0
    {4'b1111, 4'b0100, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0010, 4'b0000}, // R3 t1
    {4'b1111, 4'b0100, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0100}, // R4 t2 recycled
    {4'b1111, 4'b0000, 1'b1, 2'd2, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R5 ctrl
    {4'b1111, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b1000, 4'b0000}, // R6 t3 held
    {4'b0000, 4'b0010, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0010}, // R2 t1 rec only
    {4'b0001, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R3 wrap
    {4'b0011, 4'b0000, 1'b0, 2'd0, 4'b0010, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R7 t1 miss
    {4'b0010, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R7 asleep
    {4'b0010, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b1, 4'b0010, 4'b0010, 4'b0000}, // R7 woken
    {4'b0100, 4'b0000, 1'b0, 2'd0, 4'b0100, 1'b1, 4'b0100, 4'b0100, 4'b0000}, // R8 wake beats miss
    {4'b1000, 4'b0000, 1'b1, 2'd1, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R10 info only
    {4'b0000, 4'b0000, 1'b1, 2'd3, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R9 replace
    {4'b0000, 4'b0000, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R9 instr
    {4'b1000, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b1000, 4'b0000}, // R6 t3
    {4'b0000, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R11 idle, R8 no strobe
    {4'b0011, 4'b0000, 1'b0, 2'd0, 4'b0001, 1'b1, 4'b0010, 4'b0010, 4'b0000}, // R7 miss t0, wake t1
    {4'b0001, 4'b0000, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}  // R7 t0 still asleep
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] thrNormValid = '0, thrRecValid = '0, missSleep = '0, wakeThreadOh = '0;
  logic [N*ADDR_W-1:0] thrNormAddr, thrRecAddr;
  logic ctrlValid = 1'b0, wakeStrobe = 1'b0;
  logic [1:0] ctrlCmd = '0;
  logic [IDX_W-1:0] tagReadIdx;
  logic [N-1:0] normDequeue, recycleAck;
  logic stgValid, stgFromCtrl, stgUpdData, stgEvict;
  logic [ADDR_W-1:0] stgAddr;
  logic [1:0] stgThread;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_req_arbiter uut (
    .clk(clk), .rstN(rstN), .thrNormValid(thrNormValid), .thrRecValid(thrRecValid),
    .thrNormAddr(thrNormAddr), .thrRecAddr(thrRecAddr), .ctrlValid(ctrlValid),
    .ctrlCmd(ctrlCmd), .ctrlAddr(CTRL_ADDR), .missSleep(missSleep),
    .wakeStrobe(wakeStrobe), .wakeThreadOh(wakeThreadOh), .tagReadIdx(tagReadIdx),
    .normDequeue(normDequeue), .recycleAck(recycleAck), .stgValid(stgValid),
    .stgAddr(stgAddr), .stgThread(stgThread), .stgFromCtrl(stgFromCtrl),
    .stgUpdData(stgUpdData), .stgEvict(stgEvict)
  );

  function automatic logic [ADDR_W-1:0] nAddr(int t);
    return {8'(8'h10 + t), 6'(6'h08 + t)};
  endfunction
  function automatic logic [ADDR_W-1:0] rAddr(int t);
    return {8'(8'h20 + t), 6'(6'h18 + t)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int t = 0; t < N; t++) begin
      thrNormAddr[t*ADDR_W +: ADDR_W] = nAddr(t);
      thrRecAddr[t*ADDR_W +: ADDR_W]  = rAddr(t);
    end
    repeat (3) @(posedge clk);
    #1;
    chk(stgValid == 1'b0, "R1 reset stage valid", 32'(stgValid), 0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      logic [3:0] eN, eR, eG;
      logic cv; logic [1:0] cmd;
      int w; logic expV; logic [ADDR_W-1:0] expA;
      @(negedge clk);
      {thrNormValid, thrRecValid, cv, cmd, missSleep, wakeStrobe, wakeThreadOh, eN, eR} = VEC[i];
      ctrlValid = cv; ctrlCmd = cmd;
      eG = eN | eR; w = 0;
      for (int t = 0; t < N; t++) if (eG[t]) w = t;
      expA = cv ? CTRL_ADDR : (eG == 0) ? '0 : (eR != 0) ? rAddr(w) : nAddr(w);
      expV = cv ? (cmd != 2'd1) : (eG != 0);
      #1;
      chk(normDequeue == eN, "R2 R3 R6 R7 R8 normal dequeue", 32'(normDequeue), 32'(eN));
      chk(recycleAck == eR, "R4 recycle ack", 32'(recycleAck), 32'(eR));
      chk(tagReadIdx == expA[IDX_W-1:0], "R5 tag read index", 32'(tagReadIdx), 32'(expA[IDX_W-1:0]));
      @(posedge clk); #1;
      chk(stgValid == expV, "R10 R11 stage valid", 32'(stgValid), 32'(expV));
      if (expV) begin
        chk(stgAddr == expA, "R11 stage address", 32'(stgAddr), 32'(expA));
        chk(stgFromCtrl == cv, "R5 stage source", 32'(stgFromCtrl), 32'(cv));
        chk(stgUpdData == (cv && cmd[1]), "R9 update-with-data", 32'(stgUpdData), 32'(cv && cmd[1]));
        chk(stgEvict == (cv && cmd == 2'd3), "R9 evict", 32'(stgEvict), 32'(cv && cmd == 2'd3));
        if (!cv) chk(stgThread == 2'(w), "R11 stage thread", 32'(stgThread), 32'(w));
      end
    end

    // R1: mid-run reset clears sleeping t0 and returns rotation to thread 0
    @(negedge clk);
    rstN = 1'b0; thrNormValid = '0; missSleep = '0; wakeStrobe = 1'b0; ctrlValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1; thrNormValid = 4'b1111;
    #1;
    chk(normDequeue == 4'b0001, "R1 grant after reset", 32'(normDequeue), 32'h1);
    @(posedge clk); #1;
    chk(stgValid && stgAddr == nAddr(0), "R1 stage after reset", 32'(stgAddr), 32'(nAddr(0)));
    finishRun();
  end
endmodule